// File: doc/BRIEF.md
# Streaming Shift-Scaled Gradient Descent Row Updater

This block applies one gradient-descent step to the trainable parameters of a single layer-to-layer junction of a sparse neural network. The parameters live in a simple dual-port memory. Each word of that memory holds one row: a group of weights and, next to them, the biases of the right-side neurons that those weights feed. For every row the caller supplies one left activation per weight and one delta per right neuron. The block then reads the row, subtracts the scaled gradient from every weight and bias, and writes the row back to the same address two cycles later. One row can be processed every cycle.

The learning rate is always a power of two, so the multiply by it is an arithmetic right shift. The shift amount is held in a register and follows an epoch schedule. It starts at a parameter value. It grows by one on the second end-of-epoch pulse and then on every fourth pulse after that, and it stops at a parameter limit. All values use a signed 12-bit format with 8 fractional bits. Every result saturates instead of wrapping.

Top module: `sgd_row_updater`

## Requirements
- R1: While reset is asserted and right after it, `wr_en_o` is 0 and `lr_shift_o` equals `SHIFT_INIT` (default 3, learning rate 1/8).
- R2: In a cycle with `step_i` high, `rd_en_o` is high in that same cycle. `rd_addr_o` gives the row pointer, which is 0 after reset, advances by one per step and returns to 0 after `ROWS-1`.
- R3: A row read in cycle t is written back in cycle t+2, with `wr_en_o` high and `wr_addr_o` equal to the read address.
- R4: Weight slot k becomes w − floor(a_k·d / 2^(8+s)). Here a_k is activation k, d is the delta of the weight's neuron and s is the shift amount that was in force in the step cycle. All values are raw 12-bit integers.
- R5: Bias slot j becomes b − floor(d_j / 2^s).
- R6: A result above 2047 is written as 2047, and a result below −2048 is written as −2048.
- R7: In a row word, slot n occupies bits [12n+11:12n]. Slots 0..N_W−1 are weights and slots N_W..N_W+N_B−1 are biases. Weight k uses delta slot k/(N_W/N_B) of `delta_i`, and activation k occupies bits [12k+11:12k] of `act_i`.
- R8: After n end-of-epoch pulses, the shift equals min(SHIFT_LIMIT, SHIFT_INIT + (n≥2 ? 1+(n−2)/4 : 0)). Without a pulse the shift does not change.
- R9: Steps given on consecutive cycles produce writes on consecutive cycles, in order, with no row dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Process the next row this cycle |
| act_i | input | N_W*12 | Left activations, one per weight |
| delta_i | input | N_B*12 | Right-neuron deltas |
| epoch_done_i | input | 1 | One-cycle pulse at the end of each epoch |
| rd_en_o | output | 1 | Memory read enable |
| rd_addr_o | output | clog2(ROWS) | Memory read row |
| rd_data_i | input | (N_W+N_B)*12 | Row word, one cycle after the read |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | clog2(ROWS) | Memory write row |
| wr_data_o | output | (N_W+N_B)*12 | Updated row word |
| lr_shift_o | output | SHIFT_W | Current learning-rate shift amount |

## Verification
The bench targets rounding of negative tiny gradients. A design that truncates toward zero instead of flooring leaves the weight unchanged where the expected result moves it up by one. It drives products and sums past both rails: a design that wraps writes a value of the wrong sign. Distinct deltas per neuron expose a wrong weight-to-delta grouping or a misplaced bias slot. A burst of back-to-back steps across the address wrap catches a write address that is off by a cycle or a pointer that wraps late. Twenty epoch pulses catch a schedule that halves on the wrong pulse or goes past its limit.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int FX_W    = 12;
  localparam int FX_FRAC = 8;
  localparam int FX_MAX  = (1 << (FX_W - 1)) - 1;
  localparam int FX_MIN  = -(1 << (FX_W - 1));
  typedef logic signed [FX_W-1:0] fx_t;
endpackage

// File: rtl/sgd_lr_sched.sv
module sgd_lr_sched #(
  parameter int SHIFT_W      = 4,
  parameter int SHIFT_INIT   = 3,
  parameter int SHIFT_LIMIT  = 7,
  parameter int FIRST_EPOCHS = 2,
  parameter int LATER_EPOCHS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               epoch_done_i,
  output logic [SHIFT_W-1:0] shift_o
);
  localparam int CNT_W = $clog2(FIRST_EPOCHS > LATER_EPOCHS ? FIRST_EPOCHS : LATER_EPOCHS) + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    if (cnt_q == '0) begin
      cnt_d = CNT_W'(LATER_EPOCHS - 1);
      if (shift_q < SHIFT_W'(SHIFT_LIMIT)) shift_d = shift_q + 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(FIRST_EPOCHS - 1);
      shift_q <= SHIFT_W'(SHIFT_INIT);
    end else if (epoch_done_i) begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/sgd_lane.sv
module sgd_lane
  import sgd_pkg::*;
#(
  parameter int SHIFT_W = 4
) (
  input  fx_t                old_i,
  input  fx_t                act_i,
  input  fx_t                delta_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output fx_t                new_o
);
  localparam int PROD_W = 2 * FX_W;
  localparam int SH_W   = $clog2(PROD_W) + 1;

  logic signed [PROD_W-1:0] prod, term;
  logic signed [PROD_W:0]   diff;
  logic [SH_W-1:0]          sh_tot;

  always_comb begin
    prod   = PROD_W'(act_i) * PROD_W'(delta_i);
    sh_tot = SH_W'(FX_FRAC) + SH_W'(shift_i);
    term   = prod >>> sh_tot;
    diff   = (PROD_W+1)'(old_i) - (PROD_W+1)'(term);
    if (diff > (PROD_W+1)'(FX_MAX))      new_o = fx_t'(FX_MAX);
    else if (diff < (PROD_W+1)'(FX_MIN)) new_o = fx_t'(FX_MIN);
    else                                 new_o = diff[FX_W-1:0];
  end
endmodule

// File: rtl/sgd_row_updater.sv
module sgd_row_updater
  import sgd_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int N_W         = 4,
  parameter int N_B         = 2,
  parameter int SHIFT_W     = 4,
  parameter int SHIFT_INIT  = 3,
  parameter int SHIFT_LIMIT = 7,
  localparam int ROW_AW     = $clog2(ROWS),
  localparam int SLOTS      = N_W + N_B,
  localparam int ROW_BITS   = SLOTS * FX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_i,
  input  logic [N_W*FX_W-1:0]   act_i,
  input  logic [N_B*FX_W-1:0]   delta_i,
  input  logic                  epoch_done_i,
  output logic                  rd_en_o,
  output logic [ROW_AW-1:0]     rd_addr_o,
  input  logic [ROW_BITS-1:0]   rd_data_i,
  output logic                  wr_en_o,
  output logic [ROW_AW-1:0]     wr_addr_o,
  output logic [ROW_BITS-1:0]   wr_data_o,
  output logic [SHIFT_W-1:0]    lr_shift_o
);
  localparam int PER = N_W / N_B;

  logic [SHIFT_W-1:0]  shift;
  logic [ROW_AW-1:0]   row_q, row_d;
  logic                s1_vld_q, s2_vld_q;
  logic [ROW_AW-1:0]   s1_addr_q, s2_addr_q;
  logic [N_W*FX_W-1:0] s1_act_q;
  logic [N_B*FX_W-1:0] s1_dlt_q;
  logic [SHIFT_W-1:0]  s1_shift_q;
  logic [ROW_BITS-1:0] upd_row, s2_row_q;

  sgd_lr_sched #(
    .SHIFT_W     (SHIFT_W),
    .SHIFT_INIT  (SHIFT_INIT),
    .SHIFT_LIMIT (SHIFT_LIMIT)
  ) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .epoch_done_i (epoch_done_i),
    .shift_o      (shift)
  );

  // row pointer next state
  always_comb begin
    row_d = (row_q == ROW_AW'(ROWS - 1)) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (step_i) row_q <= row_d;
  end

  // stage 1: capture operands alongside the memory read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_addr_q  <= '0;
      s1_act_q   <= '0;
      s1_dlt_q   <= '0;
      s1_shift_q <= '0;
    end else if (step_i) begin
      s1_addr_q  <= row_q;
      s1_act_q   <= act_i;
      s1_dlt_q   <= delta_i;
      s1_shift_q <= shift;
    end
  end

  // per-slot update lanes
  for (genvar k = 0; k < N_W; k++) begin : g_w
    sgd_lane #(.SHIFT_W(SHIFT_W)) u_lane (
      .old_i   (rd_data_i[k*FX_W +: FX_W]),
      .act_i   (s1_act_q[k*FX_W +: FX_W]),
      .delta_i (s1_dlt_q[(k/PER)*FX_W +: FX_W]),
      .shift_i (s1_shift_q),
      .new_o   (upd_row[k*FX_W +: FX_W])
    );
  end
  for (genvar j = 0; j < N_B; j++) begin : g_b
    sgd_lane #(.SHIFT_W(SHIFT_W)) u_lane (
      .old_i   (rd_data_i[(N_W+j)*FX_W +: FX_W]),
      .act_i   (fx_t'(1 << FX_FRAC)),
      .delta_i (s1_dlt_q[j*FX_W +: FX_W]),
      .shift_i (s1_shift_q),
      .new_o   (upd_row[(N_W+j)*FX_W +: FX_W])
    );
  end

  // stage 2: write-back register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_vld_q <= 1'b0;
    else        s2_vld_q <= s1_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_addr_q <= '0;
      s2_row_q  <= '0;
    end else if (s1_vld_q) begin
      s2_addr_q <= s1_addr_q;
      s2_row_q  <= upd_row;
    end
  end

  assign rd_en_o    = step_i;
  assign rd_addr_o  = row_q;
  assign wr_en_o    = s2_vld_q;
  assign wr_addr_o  = s2_addr_q;
  assign wr_data_o  = s2_row_q;
  assign lr_shift_o = shift;
endmodule

// File: rtl/sgd_row_updater_chk.sv
module sgd_row_updater_chk #(
  parameter int ROW_AW      = 3,
  parameter int SHIFT_W     = 4,
  parameter int SHIFT_INIT  = 3,
  parameter int SHIFT_LIMIT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_i,
  input logic               epoch_done_i,
  input logic [ROW_AW-1:0]  rd_addr_o,
  input logic               wr_en_o,
  input logic [ROW_AW-1:0]  wr_addr_o,
  input logic [SHIFT_W-1:0] lr_shift_o
);
  a_r3_write_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> ##1 wr_en_o);

  a_r3_write_addr_matches: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o == $past(rd_addr_o, 2));

  a_r8_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_done_i |=> $stable(lr_shift_o));

  a_r8_shift_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_done_i |=> (lr_shift_o == $past(lr_shift_o)) ||
                     (lr_shift_o == $past(lr_shift_o) + 1'b1));

  a_r8_shift_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_shift_o >= SHIFT_W'(SHIFT_INIT)) && (lr_shift_o <= SHIFT_W'(SHIFT_LIMIT)));

  a_r2_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (rd_addr_o == $past(rd_addr_o) + 1'b1) || (rd_addr_o == '0));
endmodule

bind sgd_row_updater sgd_row_updater_chk #(
  .ROW_AW      (ROW_AW),
  .SHIFT_W     (SHIFT_W),
  .SHIFT_INIT  (SHIFT_INIT),
  .SHIFT_LIMIT (SHIFT_LIMIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_i       (step_i),
  .epoch_done_i (epoch_done_i),
  .rd_addr_o    (rd_addr_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .lr_shift_o   (lr_shift_o)
);

// File: tb/sgd_row_updater_bench.sv
`timescale 1ns/1ps
module sgd_row_updater_bench;
  localparam int ROWS = 8, N_W = 4, N_B = 2, SW = 4, S_INIT = 3, S_LIM = 7;
  localparam int AW = 3, RB = (N_W + N_B) * 12;

  // w, act, delta, expected weight, expected bias (shift 3)
  localparam int VEC [6][5] = '{
    '{  256,   256,  256,   224,   224},
    '{    0,  -256,  512,    64,   -64},
    '{ 2000, -2048, 2047,  2047,  1745},
    '{-2000,  2047, 2047, -2048, -2048},
    '{   10,     1,   -1,    11,    11},
    '{   10,     1,    1,    10,    10}
  };

  logic clk = 0, rst_n = 0;
  logic step = 0, epoch = 0;
  logic [N_W*12-1:0] act = '0;
  logic [N_B*12-1:0] dlt = '0;
  logic rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [RB-1:0] rd_q, wr_data;
  logic [SW-1:0] shift;
  logic ld_en = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [RB-1:0] ld_data = '0;
  logic [RB-1:0] mem [ROWS];
  int checks = 0, errors = 0, exp_row = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sgd_row_updater #(.ROWS(ROWS), .N_W(N_W), .N_B(N_B), .SHIFT_W(SW),
                    .SHIFT_INIT(S_INIT), .SHIFT_LIMIT(S_LIM)) u_sgd_row_updater (
    .clk(clk), .rst_n(rst_n), .step_i(step), .act_i(act), .delta_i(dlt),
    .epoch_done_i(epoch), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_q),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .lr_shift_o(shift));

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int slot(input logic [RB-1:0] r, input int n);
    return int'($signed(r[n*12 +: 12]));
  endfunction

  task automatic load_all(input int w, input int b);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = AW'(r);
      for (int n = 0; n < N_W + N_B; n++) ld_data[n*12 +: 12] = 12'(n < N_W ? w : b);
    end
    @(negedge clk) ld_en = 0;
  endtask

  // one step; returns the written row after checking R2/R3 timing
  task automatic run_row(output logic [RB-1:0] res);
    @(negedge clk);
    step = 1;
    #0.1;
    chk("R2 rd_en", int'(rd_en), 1);
    chk("R2 rd_addr", int'(rd_addr), exp_row);
    @(negedge clk) step = 0;
    @(negedge clk);
    chk("R3 wr_en", int'(wr_en), 1);
    chk("R3 wr_addr", int'(wr_addr), exp_row);
    res = wr_data;
    exp_row = (exp_row + 1) % ROWS;
  endtask

  function automatic int exp_shift(input int n);
    int s = S_INIT + ((n >= 2) ? 1 + (n - 2) / 4 : 0);
    return (s > S_LIM) ? S_LIM : s;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [RB-1:0] res;
    repeat (3) @(negedge clk);
    chk("R1 wr_en in reset", int'(wr_en), 0);
    chk("R1 shift in reset", int'(shift), S_INIT);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_en after reset", int'(wr_en), 0);
    chk("R1 shift after reset", int'(shift), S_INIT);

    // table of vectors: R4 weight, R5 bias, R6 saturation
    foreach (VEC[i]) begin
      load_all(VEC[i][0], VEC[i][0]);
      act = {N_W{12'(VEC[i][1])}};
      dlt = {N_B{12'(VEC[i][2])}};
      run_row(res);
      chk($sformatf("R4 R6 weight vec%0d", i), slot(res, 0), VEC[i][3]);
      chk($sformatf("R5 R6 bias vec%0d", i), slot(res, N_W), VEC[i][4]);
    end

    // R7 layout: distinct deltas and activations per slot
    load_all(0, 0);
    act = {12'sd512, 12'sd256, 12'sd512, 12'sd256};
    dlt = {12'sd512, 12'sd256};
    run_row(res);
    chk("R7 weight0", slot(res, 0), -32);
    chk("R7 weight1", slot(res, 1), -64);
    chk("R7 weight2", slot(res, 2), -64);
    chk("R7 weight3", slot(res, 3), -128);
    chk("R7 bias0", slot(res, 4), -32);
    chk("R7 bias1", slot(res, 5), -64);

    // R9 back-to-back burst across the address wrap (rows 7,0,1,2)
    load_all(0, 0);
    act = {N_W{12'sd256}};
    dlt = {N_B{12'sd256}};
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      step = (c < 4);
      #0.1;
      if (c < 4) chk("R9 R2 burst rd_addr", int'(rd_addr), (exp_row + c) % ROWS);
      if (c >= 2) begin
        chk("R9 burst wr_en", int'(wr_en), 1);
        chk("R9 burst wr_addr", int'(wr_addr), (exp_row + c - 2) % ROWS);
        chk("R9 burst data", slot(wr_data, 0), -32);
      end
    end
    step = 0;
    @(negedge clk);
    chk("R9 burst ends", int'(wr_en), 0);
    exp_row = (exp_row + 4) % ROWS;

    // R8 learning-rate schedule
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk) epoch = 1;
      @(negedge clk) epoch = 0;
      chk($sformatf("R8 shift after %0d epochs", n), int'(shift), exp_shift(n));
      @(negedge clk);
      chk("R8 shift holds without pulse", int'(shift), exp_shift(n));
    end

    // R4 R5 with the final shift of 7
    load_all(0, 0);
    run_row(res);
    chk("R4 weight at shift 7", slot(res, 0), -2);
    chk("R5 bias at shift 7", slot(res, N_W), -2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule